// File: doc/BRIEF.md
# Indexed RTC and configuration RAM

This block is a small real-time-clock register file combined with a general-purpose byte store. A host reaches every byte through two bus locations. It first writes a byte address to the index location, then reads or writes that byte through the data location. The index stays where it was put, so a run of accesses to the same byte needs only one index write.

The low part of the map holds timekeeping. It has seconds, minutes and hours counters, an alarm byte for each of them, two writable control/status bytes and two read-only status bytes. A one-second `tick_i` pulse advances the time. Counting follows a 24-hour day, in BCD or in plain binary. When all three counters equal their alarm bytes, a sticky flag is raised, and a read of that flag clears it. Every other location is plain storage. The store is built with 64 or 128 bytes. In the 64-byte build, the upper half of the 7-bit address space mirrors the lower half. Reset clears the index and the control/flag state, and keeps the stored bytes and the time.

Top module: `rtc_cfg_ram`

## Requirements
- R1: A write with `bus_sel_i`=0 loads the low 7 bits of `bus_wdata_i` into the index. With `bus_sel_i`=0, `bus_rdata_o` returns the index with bit 7 as 0. With `bus_sel_i`=1, writes go to the byte the index selects, and `bus_rdata_o` shows that byte.
- R2: Data-port reads and writes leave the index unchanged.
- R3: With RAM_BYTES=64, the addresses 40h–7Fh reach the same bytes as 00h–3Fh. With RAM_BYTES=128, all 128 addresses are distinct.
- R4: The addresses 06h–09h, and 0Eh up to the top of the array, are plain read/write storage.
- R5: 00h is seconds. Its bit 7 always reads 0, and host writes to that bit have no effect.
- R6: With control byte 0Bh bit 2 = 0 (BCD), each tick moves seconds 00–59 and minutes 00–59. A wrap to 00 carries into the next counter. Hours (04h) count 00–23 and then wrap to 00.
- R7: With 0Bh bit 2 = 1 (binary), seconds and minutes count 00h–3Bh, and hours (04h) count 00h–17h.
- R8: While 0Bh bit 7 = 1, ticks leave the time unchanged.
- R9: When a tick makes seconds (00h), minutes (02h) and hours (04h) equal their alarm bytes (01h, 03h, 05h), bit 5 of 0Ch is set. It stays set until 0Ch is read, and it reads 1 while it is set.
- R10: A data-port read of 0Ch returns the flag, and the flag then reads 0 on the next read.
- R11: 0Ch and 0Dh are read-only, and writes to them are ignored. 0Dh always reads 80h. 0Ah is a fully writable byte.
- R12: Reset clears the index, 0Bh and the alarm flag. It keeps the storage bytes and the time counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| bus_en_i | input | 1 | Host access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_sel_i | input | 1 | 0 = index location, 1 = data location |
| bus_wdata_i | input | 8 | Host write data |
| bus_rdata_o | output | 8 | Read data for the location selected by bus_sel_i |

## Verification
The assertions assume two things about the inputs. A host write to a time byte never falls in the same cycle as a tick, and each access strobe lasts exactly one cycle. The carry and freeze properties also take the counters as holding values that are in range for the current mode. The stimulus respects all of this. It drives every access and every tick in separate cycles, and it loads only valid BCD or binary times. It sets the hours alarm to a value that no count can reach during random runs, so that unplanned alarm hits cannot occur. Random storage addresses are drawn so that in the 64-byte build they never alias onto a clock byte.

// File: rtl/rtc_cfg_pkg.sv
`timescale 1ns/1ps
package rtc_cfg_pkg;
  localparam logic [3:0] A_SEC     = 4'h0;
  localparam logic [3:0] A_SEC_ALM = 4'h1;
  localparam logic [3:0] A_MIN     = 4'h2;
  localparam logic [3:0] A_MIN_ALM = 4'h3;
  localparam logic [3:0] A_HR      = 4'h4;
  localparam logic [3:0] A_HR_ALM  = 4'h5;
  localparam logic [3:0] A_CTLA    = 4'hA;
  localparam logic [3:0] A_CTLB    = 4'hB;
  localparam logic [3:0] A_FLAG    = 4'hC;
  localparam logic [3:0] A_FIXED   = 4'hD;

  localparam int unsigned CTLB_BIN  = 2;
  localparam int unsigned CTLB_HALT = 7;
  localparam int unsigned FLAG_ALM  = 5;
  localparam logic [7:0]  FIXED_VAL = 8'h80;

  function automatic logic [7:0] lim_ms(input logic bin);
    return bin ? 8'h3B : 8'h59;
  endfunction

  function automatic logic [7:0] lim_hr(input logic bin);
    return bin ? 8'h17 : 8'h23;
  endfunction

  // one count step with wrap at lim
  function automatic logic [7:0] step(input logic [7:0] v, input logic [7:0] lim,
                                     input logic bin);
    if (v == lim) return 8'h00;
    if (bin) return v + 8'd1;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction
endpackage

// File: rtl/rtc_host_port.sv
`timescale 1ns/1ps
module rtc_host_port #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [6:0]    wdata_i,
  output logic [6:0]    idx_o,
  output logic [AW-1:0] addr_o,
  output logic          dwr_o,
  output logic          drd_o
);
  logic [6:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (en_i && we_i && !sel_i) idx_q <= wdata_i;
  end

  assign idx_o  = idx_q;
  assign addr_o = idx_q[AW-1:0];  // small array drops upper bit -> alias
  assign dwr_o  = en_i & we_i & sel_i;
  assign drd_o  = en_i & ~we_i & sel_i;

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && we_i && !sel_i |=> idx_o == $past(wdata_i)) else $error("idx load"); // R1
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sel_i |=> $stable(idx_o)) else $error("idx hold"); // R2
endmodule

// File: rtl/rtc_time_unit.sv
`timescale 1ns/1ps
module rtc_time_unit
  import rtc_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_i,
  output logic [7:0] rdata_o
);
  logic [6:0] sec_q;
  logic [7:0] min_q, hr_q, sec_alm_q, min_alm_q, hr_alm_q, ctla_q, ctlb_q;
  logic       alm_q;
  logic       bin, run, sec_wrap, min_wrap, match;
  logic [7:0] sec_n, min_n, hr_n;

  assign bin      = ctlb_q[CTLB_BIN];
  assign run      = tick_i & ~ctlb_q[CTLB_HALT];
  assign sec_wrap = ({1'b0, sec_q} == lim_ms(bin));
  assign min_wrap = sec_wrap && (min_q == lim_ms(bin));
  assign sec_n    = step({1'b0, sec_q}, lim_ms(bin), bin);
  assign min_n    = sec_wrap ? step(min_q, lim_ms(bin), bin) : min_q;
  assign hr_n     = min_wrap ? step(hr_q, lim_hr(bin), bin) : hr_q;
  assign match    = (sec_n == sec_alm_q) && (min_n == min_alm_q) && (hr_n == hr_alm_q);

  // time and alarm bytes survive reset; host write wins over tick
  always_ff @(posedge clk_i) begin
    if (run) begin
      sec_q <= sec_n[6:0];
      min_q <= min_n;
      hr_q  <= hr_n;
    end
    if (wr_i) begin
      case (addr_i)
        A_SEC:     sec_q     <= wdata_i[6:0];
        A_SEC_ALM: sec_alm_q <= wdata_i;
        A_MIN:     min_q     <= wdata_i;
        A_MIN_ALM: min_alm_q <= wdata_i;
        A_HR:      hr_q      <= wdata_i;
        A_HR_ALM:  hr_alm_q  <= wdata_i;
        A_CTLA:    ctla_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctlb_q <= '0;
      alm_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTLB) ctlb_q <= wdata_i;
      if (run && match) alm_q <= 1'b1;  // new hit beats clear
      else if (clr_i)   alm_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_SEC:     rdata_o = {1'b0, sec_q};
      A_SEC_ALM: rdata_o = sec_alm_q;
      A_MIN:     rdata_o = min_q;
      A_MIN_ALM: rdata_o = min_alm_q;
      A_HR:      rdata_o = hr_q;
      A_HR_ALM:  rdata_o = hr_alm_q;
      A_CTLA:    rdata_o = ctla_q;
      A_CTLB:    rdata_o = ctlb_q;
      A_FLAG:    rdata_o = 8'(alm_q) << FLAG_ALM;
      A_FIXED:   rdata_o = FIXED_VAL;
      default:   rdata_o = 8'h00;
    endcase
  end

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !wr_i && ({1'b0, sec_q} == (ctlb_q[CTLB_BIN] ? 8'h3B : 8'h59)) |=> sec_q == 7'd0)
    else $error("sec wrap"); // R6
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctlb_q[CTLB_HALT] && !wr_i |=> $stable(sec_q) && $stable(min_q) && $stable(hr_q))
    else $error("halt"); // R8
  AST_ALM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_q && !clr_i |=> alm_q) else $error("alm sticky"); // R9
  AST_ALM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !tick_i |=> !alm_q) else $error("alm clear"); // R10
endmodule

// File: rtl/rtc_cfg_store.sv
`timescale 1ns/1ps
module rtc_cfg_store #(
  parameter int unsigned RAM_BYTES = 64,
  localparam int unsigned AW = $clog2(RAM_BYTES)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [RAM_BYTES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rtc_cfg_ram.sv
`timescale 1ns/1ps
module rtc_cfg_ram #(
  parameter int unsigned RAM_BYTES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       bus_en_i,
  input  logic       bus_we_i,
  input  logic       bus_sel_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o
);
  localparam int unsigned AW = $clog2(RAM_BYTES);

  logic [6:0]    idx;
  logic [AW-1:0] addr;
  logic          dwr, drd, in_clk;
  logic [7:0]    t_rd, s_rd;

  rtc_host_port #(.AW(AW)) u_port (
    .clk_i, .rst_ni,
    .en_i(bus_en_i), .we_i(bus_we_i), .sel_i(bus_sel_i),
    .wdata_i(bus_wdata_i[6:0]),
    .idx_o(idx), .addr_o(addr), .dwr_o(dwr), .drd_o(drd)
  );

  // 00h-05h and 0Ah-0Dh belong to the clock
  assign in_clk = (addr < AW'(6)) || ((addr >= AW'(10)) && (addr < AW'(14)));

  rtc_time_unit u_time (
    .clk_i, .rst_ni, .tick_i,
    .wr_i(dwr && in_clk), .addr_i(addr[3:0]), .wdata_i(bus_wdata_i),
    .clr_i(drd && addr == AW'(12)), .rdata_o(t_rd)
  );

  rtc_cfg_store #(.RAM_BYTES(RAM_BYTES)) u_store (
    .clk_i, .we_i(dwr && !in_clk), .addr_i(addr),
    .wdata_i(bus_wdata_i), .rdata_o(s_rd)
  );

  assign bus_rdata_o = !bus_sel_i ? {1'b0, idx} : (in_clk ? t_rd : s_rd);
endmodule

// File: tb/tb_rtc_cfg_ram.sv
`timescale 1ns/1ps
module tb_rtc_cfg_ram;
  logic clk = 0, rst_n = 0, tick = 0, en = 0, we = 0, sel = 0;
  logic [7:0] wd = 0, rd_s, rd_w;
  int checks = 0, fails = 0;
  logic [7:0] m64 [64];
  logic [7:0] m128 [128];
  bit v64 [64];
  bit v128 [128];

  always #2.5 clk = ~clk;

  rtc_cfg_ram #(.RAM_BYTES(64)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_en_i(en), .bus_we_i(we),
    .bus_sel_i(sel), .bus_wdata_i(wd), .bus_rdata_o(rd_s));
  rtc_cfg_ram #(.RAM_BYTES(128)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_en_i(en), .bus_we_i(we),
    .bus_sel_i(sel), .bus_wdata_i(wd), .bus_rdata_o(rd_w));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus(input logic s, input logic [7:0] d);
    @(negedge clk); en = 1; we = 1; sel = s; wd = d;
    @(negedge clk); en = 0; we = 0;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    bus(0, a); bus(1, d);
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] r, output logic [7:0] rw);
    bus(0, a);
    @(negedge clk); en = 1; we = 0; sel = 1;
    #1 r = rd_s; rw = rd_w;
    @(negedge clk); en = 0;
  endtask

  task automatic rd_idx(output logic [7:0] r, output logic [7:0] rw);
    @(negedge clk); en = 0; sel = 0;
    #1 r = rd_s; rw = rd_w;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [7:0] enc(input int v, input bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit clk_addr(input int a);
    return (a < 6) || (a >= 10 && a < 14);
  endfunction

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr_byte(8'h04, h); wr_byte(8'h02, m); wr_byte(8'h00, s);
  endtask

  task automatic chk_time(input string req, input logic [7:0] h, input logic [7:0] m,
                          input logic [7:0] s);
    logic [7:0] a, b;
    rd_byte(8'h00, a, b); chk({req, " sec"}, a, s); chk({req, " sec w"}, b, s);
    rd_byte(8'h02, a, b); chk({req, " min"}, a, m); chk({req, " min w"}, b, m);
    rd_byte(8'h04, a, b); chk({req, " hr"}, a, h); chk({req, " hr w"}, b, h);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    rd_idx(a, b); chk("R12 idx after reset", a, 8'h00); chk("R12 idx after reset w", b, 8'h00);
    rd_byte(8'h0B, a, b); chk("R12 ctlb reset", a, 8'h00);
    rd_byte(8'h0C, a, b); chk("R12 flag reset", a, 8'h00);
    rd_byte(8'h0D, a, b); chk("R11 fixed byte", a, 8'h80); chk("R11 fixed byte w", b, 8'h80);

    // R1 index and data path
    bus(0, 8'hA5);
    rd_idx(a, b); chk("R1 idx readback", a, 8'h25); chk("R1 idx readback w", b, 8'h25);
    wr_byte(8'h25, 8'h5A); m64[8'h25] = 8'h5A; m128[8'h25] = 8'h5A; v64[8'h25] = 1; v128[8'h25] = 1;
    rd_byte(8'h25, a, b); chk("R1 data rw", a, 8'h5A); chk("R1 data rw w", b, 8'h5A);
    // R2 index held after data accesses
    rd_idx(a, b); chk("R2 idx held", a, 8'h25);
    bus(1, 8'h77); m64[8'h25] = 8'h77; m128[8'h25] = 8'h77;
    rd_idx(a, b); chk("R2 idx held after write", a, 8'h25); chk("R2 idx held after write w", b, 8'h25);

    // R3 aliasing
    wr_byte(8'h30, 8'h11); wr_byte(8'h70, 8'h22);
    m64[8'h30] = 8'h22; v64[8'h30] = 1;
    m128[8'h30] = 8'h11; m128[8'h70] = 8'h22; v128[8'h30] = 1; v128[8'h70] = 1;
    rd_byte(8'h30, a, b); chk("R3 alias low", a, 8'h22); chk("R3 distinct low", b, 8'h11);
    rd_byte(8'h70, a, b); chk("R3 alias high", a, 8'h22); chk("R3 distinct high", b, 8'h22);

    // R4 plain storage edges
    for (int i = 6; i < 10; i++) begin
      wr_byte(8'(i), 8'(8'hC0 + i)); m64[i] = 8'(8'hC0 + i); m128[i] = 8'(8'hC0 + i);
      v64[i] = 1; v128[i] = 1;
    end
    wr_byte(8'h0E, 8'h3C); m64[14] = 8'h3C; m128[14] = 8'h3C; v64[14] = 1; v128[14] = 1;
    wr_byte(8'h7F, 8'hE1); m64[63] = 8'hE1; m128[127] = 8'hE1; v64[63] = 1; v128[127] = 1;
    rd_byte(8'h07, a, b); chk("R4 storage 07", a, 8'hC7); chk("R4 storage 07 w", b, 8'hC7);
    rd_byte(8'h0E, a, b); chk("R4 storage 0E", a, 8'h3C);
    rd_byte(8'h3F, a, b); chk("R4 storage top small", a, 8'hE1);
    rd_byte(8'h7F, a, b); chk("R4 storage top wide", b, 8'hE1);

    // R5 seconds bit 7
    wr_byte(8'h00, 8'hFF);
    rd_byte(8'h00, a, b); chk("R5 sec bit7", a, 8'h7F); chk("R5 sec bit7 w", b, 8'h7F);

    // R11 read-only and writable status
    wr_byte(8'h0C, 8'hFF); wr_byte(8'h0D, 8'h00); wr_byte(8'h0A, 8'h6B);
    rd_byte(8'h0C, a, b); chk("R11 flag ro", a, 8'h00);
    rd_byte(8'h0D, a, b); chk("R11 fixed ro", a, 8'h80);
    rd_byte(8'h0A, a, b); chk("R11 ctla rw", a, 8'h6B);

    // R6 BCD counting and carry
    wr_byte(8'h0B, 8'h00);
    wr_byte(8'h01, 8'h11); wr_byte(8'h03, 8'h11); wr_byte(8'h05, 8'h3F);
    set_time(8'h23, 8'h59, 8'h58);
    do_tick(1); chk_time("R6 bcd 59", 8'h23, 8'h59, 8'h59);
    do_tick(1); chk_time("R6 bcd day wrap", 8'h00, 8'h00, 8'h00);
    set_time(8'h09, 8'h09, 8'h09);
    do_tick(1); chk_time("R6 bcd nibble", 8'h09, 8'h09, 8'h10);
    set_time(8'h09, 8'h59, 8'h59);
    do_tick(1); chk_time("R6 bcd hour carry", 8'h10, 8'h00, 8'h00);

    // R7 binary counting
    wr_byte(8'h0B, 8'h04);
    set_time(8'h05, 8'h06, 8'h09);
    do_tick(1); chk_time("R7 bin step", 8'h05, 8'h06, 8'h0A);
    set_time(8'h17, 8'h3B, 8'h3B);
    do_tick(1); chk_time("R7 bin day wrap", 8'h00, 8'h00, 8'h00);

    // R8 halt
    wr_byte(8'h0B, 8'h80);
    rd_byte(8'h0B, a, b); chk("R1 ctlb readback", a, 8'h80);
    set_time(8'h01, 8'h02, 8'h10);
    do_tick(3); chk_time("R8 halt", 8'h01, 8'h02, 8'h10);

    // R9 / R10 alarm
    wr_byte(8'h0B, 8'h00);
    wr_byte(8'h01, 8'h59); wr_byte(8'h03, 8'h34); wr_byte(8'h05, 8'h12);
    set_time(8'h12, 8'h34, 8'h58);
    do_tick(1);
    rd_byte(8'h0C, a, b); chk("R9 alarm set", a, 8'h20); chk("R9 alarm set w", b, 8'h20);
    rd_byte(8'h0C, a, b); chk("R10 alarm cleared", a, 8'h00); chk("R10 alarm cleared w", b, 8'h00);
    set_time(8'h12, 8'h34, 8'h58);
    do_tick(3);
    rd_byte(8'h0C, a, b); chk("R9 alarm sticky", a, 8'h20);
    rd_byte(8'h0C, a, b); chk("R10 alarm cleared again", a, 8'h00);
    wr_byte(8'h05, 8'h3F);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op, ad, e;
      op = int'($urandom % 3);
      if (op < 2) begin
        do begin ad = int'($urandom % 128); end while (clk_addr(ad & 63));
        e = ad & 63;
        if (op == 0) begin
          logic [7:0] d;
          d = 8'($urandom);
          wr_byte(8'(ad), d); m64[e] = d; m128[ad] = d; v64[e] = 1; v128[ad] = 1;
        end else begin
          rd_byte(8'(ad), a, b);
          if (v64[e]) chk("R4 random small", a, m64[e]);
          if (v128[ad]) chk("R3 random wide", b, m128[ad]);
        end
      end else begin
        bit bn;
        int h, m, s, n, t;
        bn = bit'($urandom % 2);
        h = int'($urandom % 24); m = int'($urandom % 60); s = int'($urandom % 60);
        n = 1 + int'($urandom % 70);
        wr_byte(8'h0B, bn ? 8'h04 : 8'h00);
        set_time(enc(h, bn), enc(m, bn), enc(s, bn));
        do_tick(n);
        t = (h * 3600 + m * 60 + s + n) % 86400;
        chk_time(bn ? "R7 random" : "R6 random",
                 enc(t / 3600, bn), enc((t / 60) % 60, bn), enc(t % 60, bn));
      end
    end

    // R12 reset keeps storage and time, clears control
    wr_byte(8'h0B, 8'h00);
    wr_byte(8'h01, 8'h59); wr_byte(8'h03, 8'h34); wr_byte(8'h05, 8'h12);
    set_time(8'h12, 8'h34, 8'h58);
    do_tick(1);
    wr_byte(8'h0B, 8'h84);
    wr_byte(8'h20, 8'h9D); wr_byte(8'h60, 8'h4E);
    do_reset();
    rd_idx(a, b); chk("R12 idx cleared", a, 8'h00); chk("R12 idx cleared w", b, 8'h00);
    rd_byte(8'h0B, a, b); chk("R12 ctlb cleared", a, 8'h00);
    rd_byte(8'h0C, a, b); chk("R12 flag cleared", a, 8'h00);
    rd_byte(8'h20, a, b); chk("R12 storage kept", a, 8'h4E); chk("R12 storage kept w", b, 8'h9D);
    rd_byte(8'h60, a, b); chk("R12 storage kept high w", b, 8'h4E);
    rd_byte(8'h00, a, b); chk("R12 time kept", a, 8'h59);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule